// File: doc/BRIEF.md
# Global-History Hashed Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters and a shift register with the outcomes of the most recent resolved branches. A lookup folds the word address of the fetch PC together with that outcome history using XOR. The result picks one counter, so a single branch can train different counters under different recent histories.

The fetch stage presents a PC and gets a taken/not-taken guess and the table index in the same cycle, with no clock in between. It keeps the index with the branch. When the branch resolves, the execute stage returns that index with the real outcome. The counter at that index is trained, and the outcome is shifted into the history. The history changes only at resolution. Repairing the history after a misprediction is left to the surrounding pipeline.

Top module: `hist_xor_bpred`

## Requirements
- R1: After reset every counter holds weakly not-taken (state 1) and the history is all zeros, so every lookup predicts not-taken and reports index PC[IDX_W+1:2].
- R2: The lookup index is PC[IDX_W+1:2] XOR the history (history bit i lines up with index bit i). PC bits [1:0] have no effect on the index or the prediction.
- R3: Counter encoding is 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. The prediction output is taken exactly when the selected counter is 2 or 3, in the same cycle as the PC.
- R4: An update with outcome taken raises the selected counter by one and leaves it at 3 when it is already 3.
- R5: An update with outcome not-taken lowers the selected counter by one and leaves it at 0 when it is already 0.
- R6: From a strong state, a single opposite outcome moves the counter to the weak state of the same direction, so the prediction does not change.
- R7: Training writes the counter named by the update index input. It does not recompute the index from the current history.
- R8: On an update, the outcome enters history bit 0, each older bit moves up one place, and the oldest bit is dropped. Without an update the history holds its value.
- R9: An update takes effect at the clock edge. A lookup in the same cycle as an update sees the counter and history values from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Fetch PC to look up |
| pred_taken | output | 1 | Guessed direction (1 = taken) |
| pred_idx | output | IDX_W | Table index used for this lookup |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_idx | input | IDX_W | Index captured when that branch was looked up |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The embedded assertions check the counter stepping on every cycle with an update: the increment and decrement by one, saturation at both ends, and the weakening move out of a strong state. They also check the history on every cycle, confirming that it holds when there is no update and that the outcome lands in bit 0 when there is one. Only the bench's scenarios can show that the index really is the XOR of PC and history, that PC bits [1:0] are ignored, that reset leaves every counter weakly not-taken, and that a same-cycle lookup sees pre-update state. The bench covers these through a vector sequence compared against a model of table and history, followed by directed saturation and hysteresis runs.

// File: rtl/hist_xor_bpred.sv
module hist_xor_bpred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]        tbl [DEPTH];
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  hist_ext;
  logic [1:0]        cur;

  always_comb begin
    hist_ext = '0;
    hist_ext[HIST_W-1:0] = hist;
  end

  assign pred_idx   = pred_pc[IDX_W+1:2] ^ hist_ext;
  assign pred_taken = tbl[pred_idx][1];
  assign cur        = tbl[upd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= 2'd1;
      hist <= '0;
    end else if (upd_valid) begin
      if (upd_taken && cur != 2'd3)       tbl[upd_idx] <= cur + 2'd1;
      else if (!upd_taken && cur != 2'd0) tbl[upd_idx] <= cur - 2'd1;
      hist <= {hist[HIST_W-2:0], upd_taken};
    end
  end

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_taken && cur != 2'd3 |=> tbl[$past(upd_idx)] == $past(cur) + 2'd1);
  // R4
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_taken && cur == 2'd3 |=> tbl[$past(upd_idx)] == 2'd3);
  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_taken && cur != 2'd0 |=> tbl[$past(upd_idx)] == $past(cur) - 2'd1);
  // R5
  bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_taken && cur == 2'd0 |=> tbl[$past(upd_idx)] == 2'd0);
  // R6
  hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && (cur == 2'd0 || cur == 2'd3) |=> tbl[$past(upd_idx)][1] == $past(cur[1]));
  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist));
  // R8
  hist_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist[0] == $past(upd_taken));
endmodule

// File: tb/sim_hist_xor_bpred.sv
module sim_hist_xor_bpred;
  localparam int PC_W = 32, IDX_W = 10, HIST_W = 10, DEPTH = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pred_pc = '0;
  logic pred_taken;
  logic [IDX_W-1:0] pred_idx;
  logic upd_valid = 0, upd_taken = 0;
  logic [IDX_W-1:0] upd_idx = '0;

  hist_xor_bpred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int m_cnt [DEPTH];
  logic [HIST_W-1:0] m_hist;

  // vectors: {outcome, pc[13:0]}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    15'h4100, 15'h4100, 15'h4100, 15'h0100, 15'h4104, 15'h0208, 15'h4100, 15'h4100,
    15'h7ffc, 15'h0ffc, 15'h4010, 15'h4010, 15'h0010, 15'h4abc, 15'h0abc, 15'h4100};

  function automatic logic [IDX_W-1:0] m_idx(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2] ^ m_hist;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; upd_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) m_cnt[i] = 1;
    m_hist = '0;
  endtask

  // drive at negedge, check outputs, let the edge pass, then update the model
  task automatic step(input string req, input logic [PC_W-1:0] pc, input logic uv,
                      input logic [IDX_W-1:0] ui, input logic ut);
    @(negedge clk);
    pred_pc = pc; upd_valid = uv; upd_idx = ui; upd_taken = ut;
    #1;
    chk({req, " idx"}, int'(pred_idx), int'(m_idx(pc)));
    chk({req, " dir"}, int'(pred_taken), int'(m_cnt[m_idx(pc)] >= 2));
    @(posedge clk); #1;
    if (uv) begin
      if (ut && m_cnt[ui] < 3) m_cnt[ui]++;
      if (!ut && m_cnt[ui] > 0) m_cnt[ui]--;
      m_hist = {m_hist[HIST_W-2:0], ut};
    end
    upd_valid = 0;
  endtask

  // PC whose index under the current model history is target
  function automatic logic [PC_W-1:0] pc_for(input logic [IDX_W-1:0] target);
    logic [PC_W-1:0] p = '0;
    p[IDX_W+1:2] = target ^ m_hist;
    return p;
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    step("R1", 32'h0000_0100, 0, '0, 0);
    step("R1", 32'h0000_0ffc, 0, '0, 0);
    // R2: low PC bits ignored
    @(negedge clk); pred_pc = 32'h0000_0103; #1;
    chk("R2 low bits idx", int'(pred_idx), int'(10'h040));
    chk("R2 low bits dir", int'(pred_taken), 0);

    // R2 R3 R8: vector walk, each row looks up and trains its own index
    for (int v = 0; v < NV; v++) begin
      logic [PC_W-1:0] pc = {18'd0, VEC[v][13:0]};
      step("R2/R3/R8 vec", pc, 1, m_idx(pc), VEC[v][14]);
    end

    // R4 R6: saturate high, then hysteresis
    do_reset();
    for (int k = 0; k < 4; k++) step("R4 inc", pc_for(10'd5), 1, 10'd5, 1);
    chk("R4 sat", m_cnt[5], 3);
    step("R4 read", pc_for(10'd5), 1, 10'd5, 0);
    chk("R6 model", m_cnt[5], 2);
    @(negedge clk); pred_pc = pc_for(10'd5); #1;
    chk("R6 still taken", int'(pred_taken), 1);
    // R5: saturate low, then hysteresis the other way
    for (int k = 0; k < 4; k++) step("R5 dec", pc_for(10'd9), 1, 10'd9, 0);
    step("R5 up once", pc_for(10'd9), 1, 10'd9, 1);
    @(negedge clk); pred_pc = pc_for(10'd9); #1;
    chk("R5 R6 still not-taken", int'(pred_taken), 0);

    // R7: training uses supplied index, not the current history
    do_reset();
    step("R7 shift", 32'h0, 1, 10'd700, 1);
    step("R7 a", 32'h0, 1, 10'd3, 1);
    step("R7 b", 32'h0, 1, 10'd3, 1);
    @(negedge clk); pred_pc = pc_for(10'd3); #1;
    chk("R7 target idx", int'(pred_idx), 3);
    chk("R7 target trained", int'(pred_taken), 1);

    // R9: same-cycle lookup sees old state
    do_reset();
    step("R9 prime", pc_for(10'd20), 1, 10'd20, 1);
    @(negedge clk);
    pred_pc = pc_for(10'd20); upd_valid = 1; upd_idx = 10'd20; upd_taken = 0; #1;
    chk("R9 same cycle dir", int'(pred_taken), 1);
    chk("R9 same cycle idx", int'(pred_idx), 20);
    @(posedge clk); #1;
    upd_valid = 0; m_cnt[20] = 1; m_hist = {m_hist[HIST_W-2:0], 1'b0};
    step("R9 after", pc_for(10'd20), 0, '0, 0);
    // R8: history holds without update
    step("R8 hold", 32'h0000_0040, 0, '0, 0);
    chk("R8 hist", int'(m_hist), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule